// File: doc/BRIEF.md
# Host Adapter Control Register

This block is the 16-bit control and status word that a host processor uses to steer a network adapter. Each bit follows its own access rule. Some bits show live pin levels. Some are ordinary read/write controls. One bit can only be set. A protected group accepts writes only while the adapter is held in reset. Power-on values for several bits come from strap pins, so board wiring picks the default boot, parity and select settings.

The host uses a single-cycle synchronous write port with two byte-lane strobes. Reads are combinational. The low byte carries the pseudo-DMA handshake. Once software has enabled pseudo-DMA, an internal hold request shows up as a flag. Software answers by setting an acknowledge bit, which replaces the hardware acknowledge pin. The high byte holds the adapter reset control and the strap-loaded configuration fields. Each of these fields also drives an output pin.

Top module: `adapter_ctl_reg`

## Requirements
- R1: Reset is synchronous and active low. With strap_boot=b and strap_parity=p, reset loads these values: bit 8 = 0, bits 9 and 10 = b, bit 11 = 0, bit 12 = 1, bit 13 = p, bit 14 = 0, bit 15 = 1. Bits 7, 6, 5 and 4 load 0.
- R2: rd_data[2:0] always equals cfg_pin[2:0]. speed_code decodes as follows: cfg_pin[2]=0 gives 2'b00 (reserved); cfg_pin[2]=1 with cfg_pin[0]=0 gives 2'b10 (16 Mbps); cfg_pin[2]=1 with cfg_pin[0]=1 gives 2'b01 (4 Mbps).
- R3: rd_data bits 3 and 5 always read 0, whatever is written.
- R4: A write happens when wr_en=1 at a rising clock edge and shows up in rd_data after that edge. wr_be[0] enables bits 7:0 and wr_be[1] enables bits 15:8. Bits 8, 11 and 12 are plain read/write.
- R5: Writes to bits 9, 10, 13, 14 and 15 are ignored when bit 8 held 0 just before the write.
- R6: When bit 8 held 1 just before the write, bits 9, 10, 13, 14 and 15 take the write data. This includes a write that clears bit 8 in the same cycle.
- R7: Bit 7 (pseudo-DMA enable) is set-only. Writing 1 sets it, writing 0 leaves it unchanged, and only reset clears it.
- R8: Bit 4 (software acknowledge) can be written only when bit 7 was 1 before the write. Otherwise it stays 0.
- R9: Bit 6 (software request) ignores writes. It becomes 1 one edge after hold_req_in=1, but only while bit 7=1 and bit 4=0. It clears on the edge where a write sets bit 4.
- R10: hold_ack_eff equals bit 4 when bit 7=1. When bit 7=0 it equals the hw_hold_ack pin.
- R11: pdma_state is 2'b00 (idle) when bit 7=0, or when bits 4 and 6 are both 0. It is 2'b01 (pending) when bit 4=0 and bit 6=1. It is 2'b10 (busy) when bit 7=1 and bit 4=1.
- R12: Output pins mirror register bits: adapter_reset is bit 8, cpu_halt is bit 9, boot_sel is bit 10, diag_loop is bit 11, sys_int_en is bit 12, parity_en is bit 13, sel_out[0] is bit 14, sel_out[1] is bit 15, and pdma_en is bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 2 | Byte-lane enables (bit 0: low byte) |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Register read value |
| cfg_pin | input | 3 | Speed/type configuration pins |
| strap_boot | input | 1 | Strap giving reset value of bits 9 and 10 |
| strap_parity | input | 1 | Strap giving reset value of bit 13 |
| hold_req_in | input | 1 | Internal pseudo-DMA hold request |
| hw_hold_ack | input | 1 | Hardware hold-acknowledge pin |
| speed_code | output | 2 | Decoded speed from cfg_pin |
| adapter_reset | output | 1 | Adapter reset control (bit 8) |
| cpu_halt | output | 1 | Halt control (bit 9) |
| boot_sel | output | 1 | Boot select (bit 10) |
| diag_loop | output | 1 | Diagnostic loop control (bit 11) |
| sys_int_en | output | 1 | System interrupt enable (bit 12) |
| parity_en | output | 1 | Parity enable (bit 13) |
| sel_out | output | 2 | Select outputs (bits 14, 15) |
| pdma_en | output | 1 | Pseudo-DMA enable (bit 7) |
| hold_ack_eff | output | 1 | Acknowledge seen by the transfer logic |
| pdma_state | output | 2 | Pseudo-DMA handshake state |

## Verification
The hardest case to reach is the protected-group write that lands in the same cycle that drops bit 8. To reach it, the stimulus must first raise bit 8 with a write to the high byte. Only then does it send one high-byte write that clears bit 8 while setting a new pattern in the protected bits. The handshake states are also gated: they need pseudo-DMA enabled first and a timed one-cycle request pulse. The bench therefore also covers the disabled case, where the same request and acknowledge writes must leave no trace.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CFG_W  = 3;

  // low byte positions
  localparam int B_RSV3  = 3;
  localparam int B_SWACK = 4;
  localparam int B_RSV5  = 5;
  localparam int B_SWREQ = 6;
  localparam int B_PDMA  = 7;

  // high byte, indices relative to bit 8
  localparam int H_ARST = 0;
  localparam int H_HALT = 1;
  localparam int H_BOOT = 2;
  localparam int H_LOOP = 3;
  localparam int H_SINT = 4;
  localparam int H_PAR  = 5;
  localparam int H_SEL0 = 6;
  localparam int H_SEL1 = 7;

  localparam logic [BYTE_W-1:0] HI_RW_MASK   = 8'b0001_1001;
  localparam logic [BYTE_W-1:0] HI_PROT_MASK = 8'b1110_0110;

  typedef enum logic [1:0] {
    SPD_RSVD = 2'b00,
    SPD_4M   = 2'b01,
    SPD_16M  = 2'b10
  } speed_e;

  typedef enum logic [1:0] {
    PD_IDLE = 2'b00,
    PD_PEND = 2'b01,
    PD_BUSY = 2'b10
  } pdma_state_e;

  function automatic speed_e speed_of(input logic [CFG_W-1:0] p);
    if (!p[2])     return SPD_RSVD;
    else if (p[0]) return SPD_4M;
    else           return SPD_16M;
  endfunction

  function automatic pdma_state_e pdma_state_of(input logic en, input logic ack,
                                                input logic req);
    if (!en)      return PD_IDLE;
    else if (ack) return PD_BUSY;
    else if (req) return PD_PEND;
    else          return PD_IDLE;
  endfunction

  // replace the bits selected by mask with new data
  function automatic logic [BYTE_W-1:0] merge_bits(input logic [BYTE_W-1:0] old_v,
                                                   input logic [BYTE_W-1:0] new_v,
                                                   input logic [BYTE_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic [BYTE_W-1:0] hi_reset_vec(input logic boot, input logic par);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[H_HALT] = boot;
    v[H_BOOT] = boot;
    v[H_SINT] = 1'b1;
    v[H_PAR]  = par;
    v[H_SEL1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/acr_cfg_sense.sv
module acr_cfg_sense
  import acr_pkg::*;
#(
  parameter int PIN_W = CFG_W
) (
  input  logic [PIN_W-1:0] cfg_pin,
  output logic [PIN_W-1:0] cfg_bits,
  output logic [1:0]       speed_code
);
  speed_e spd;

  always_comb begin
    cfg_bits   = cfg_pin;
    spd        = speed_of(cfg_pin);
    speed_code = spd;
  end
endmodule

// File: rtl/acr_ctl_fields.sv
module acr_ctl_fields
  import acr_pkg::*;
#(
  parameter int FW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic [FW-1:0] d_hi,
  input  logic          strap_boot,
  input  logic          strap_parity,
  output logic [FW-1:0] hi_q
);
  logic          prot_open;
  logic [FW-1:0] wr_mask;
  logic [FW-1:0] hi_next;

  // the protection check uses the reset-control value held before this write
  assign prot_open = hi_q[H_ARST];

  always_comb begin
    wr_mask = HI_RW_MASK | (prot_open ? HI_PROT_MASK : '0);
    hi_next = wr_hi ? merge_bits(hi_q, d_hi, wr_mask) : hi_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hi_q <= hi_reset_vec(strap_boot, strap_parity);
    else        hi_q <= hi_next;
  end

  // R5: protected group stays put while reset-control was low
  a_r5_locked_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(hi_q[H_ARST]) |-> ((hi_q & HI_PROT_MASK) == ($past(hi_q) & HI_PROT_MASK)));
endmodule

// File: rtl/acr_pdma.sv
module acr_pdma
  import acr_pkg::*;
#(
  parameter int FW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic [FW-1:0] d_lo,
  input  logic          hold_req_in,
  input  logic          hw_hold_ack,
  output logic          pdma_en_q,
  output logic          sw_ack_q,
  output logic          sw_req_q,
  output logic          hold_ack_eff,
  output logic [1:0]    pdma_state
);
  logic        ack_write;
  logic        ack_accept;
  logic        req_fire;
  pdma_state_e st;

  assign ack_write  = wr_lo && pdma_en_q;
  assign ack_accept = ack_write && d_lo[B_SWACK];
  assign req_fire   = hold_req_in && pdma_en_q && !sw_ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdma_en_q <= 1'b0;
      sw_ack_q  <= 1'b0;
      sw_req_q  <= 1'b0;
    end else begin
      if (wr_lo && d_lo[B_PDMA]) pdma_en_q <= 1'b1;
      if (ack_write)             sw_ack_q  <= d_lo[B_SWACK];
      if (ack_accept)            sw_req_q  <= 1'b0;
      else if (req_fire)         sw_req_q  <= 1'b1;
    end
  end

  always_comb begin
    hold_ack_eff = pdma_en_q ? sw_ack_q : hw_hold_ack;
    st           = pdma_state_of(pdma_en_q, sw_ack_q, sw_req_q);
    pdma_state   = st;
  end

  // R7: the enable never drops except through reset
  a_r7_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pdma_en_q) |-> !$past(rst_n));
  // R8: acknowledge cannot be 1 without the enable
  a_r8_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !pdma_en_q |-> !sw_ack_q);
  // R9: request flag is gone once acknowledge rises
  a_r9_req_drops_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ack_q) |-> !sw_req_q);
endmodule

// File: rtl/adapter_ctl_reg.sv
module adapter_ctl_reg
  import acr_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int PW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_be,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [PW-1:0] cfg_pin,
  input  logic          strap_boot,
  input  logic          strap_parity,
  input  logic          hold_req_in,
  input  logic          hw_hold_ack,
  output logic [1:0]    speed_code,
  output logic          adapter_reset,
  output logic          cpu_halt,
  output logic          boot_sel,
  output logic          diag_loop,
  output logic          sys_int_en,
  output logic          parity_en,
  output logic [1:0]    sel_out,
  output logic          pdma_en,
  output logic          hold_ack_eff,
  output logic [1:0]    pdma_state
);
  localparam int HB = DW / 2;

  logic          wr_lo, wr_hi;
  logic [PW-1:0] cfg_bits;
  logic [HB-1:0] hi_q;
  logic          sw_ack_q, sw_req_q;

  assign wr_lo = wr_en && wr_be[0];
  assign wr_hi = wr_en && wr_be[1];

  acr_cfg_sense #(.PIN_W(PW)) u_cfg (
    .cfg_pin    (cfg_pin),
    .cfg_bits   (cfg_bits),
    .speed_code (speed_code)
  );

  acr_ctl_fields #(.FW(HB)) u_fields (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_hi        (wr_hi),
    .d_hi         (wr_data[DW-1:HB]),
    .strap_boot   (strap_boot),
    .strap_parity (strap_parity),
    .hi_q         (hi_q)
  );

  acr_pdma #(.FW(HB)) u_pdma (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_lo        (wr_lo),
    .d_lo         (wr_data[HB-1:0]),
    .hold_req_in  (hold_req_in),
    .hw_hold_ack  (hw_hold_ack),
    .pdma_en_q    (pdma_en),
    .sw_ack_q     (sw_ack_q),
    .sw_req_q     (sw_req_q),
    .hold_ack_eff (hold_ack_eff),
    .pdma_state   (pdma_state)
  );

  always_comb begin
    rd_data             = '0;
    rd_data[PW-1:0]     = cfg_bits;
    rd_data[B_SWACK]    = sw_ack_q;
    rd_data[B_SWREQ]    = sw_req_q;
    rd_data[B_PDMA]     = pdma_en;
    rd_data[DW-1:HB]    = hi_q;
  end

  assign adapter_reset = hi_q[H_ARST];
  assign cpu_halt      = hi_q[H_HALT];
  assign boot_sel      = hi_q[H_BOOT];
  assign diag_loop     = hi_q[H_LOOP];
  assign sys_int_en    = hi_q[H_SINT];
  assign parity_en     = hi_q[H_PAR];
  assign sel_out       = {hi_q[H_SEL1], hi_q[H_SEL0]};

  // R11: the handshake never reports an undefined state
  a_r11_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pdma_state != 2'b11);
endmodule

// File: tb/adapter_ctl_reg_tb.sv
module adapter_ctl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  cfg_pin = 3'b101;
  logic        strap_boot = 1'b1;
  logic        strap_parity = 1'b0;
  logic        hold_req_in = 1'b0;
  logic        hw_hold_ack = 1'b0;
  logic [1:0]  speed_code;
  logic        adapter_reset, cpu_halt, boot_sel, diag_loop, sys_int_en, parity_en;
  logic [1:0]  sel_out;
  logic        pdma_en, hold_ack_eff;
  logic [1:0]  pdma_state;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adapter_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_pin(cfg_pin), .strap_boot(strap_boot),
    .strap_parity(strap_parity), .hold_req_in(hold_req_in), .hw_hold_ack(hw_hold_ack),
    .speed_code(speed_code), .adapter_reset(adapter_reset), .cpu_halt(cpu_halt),
    .boot_sel(boot_sel), .diag_loop(diag_loop), .sys_int_en(sys_int_en),
    .parity_en(parity_en), .sel_out(sel_out), .pdma_en(pdma_en),
    .hold_ack_eff(hold_ack_eff), .pdma_state(pdma_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic boot, input logic par);
    @(negedge clk);
    rst_n = 1'b0; strap_boot = boot; strap_parity = par;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00; wr_data = '0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    hold_req_in = 1'b1;
    @(negedge clk);
    hold_req_in = 1'b0;
  endtask

  task automatic t_reset_a();
    cfg_pin = 3'b101;
    do_reset(1'b1, 1'b0);
    chk("R1 reset word boot=1 par=0", rd_data, 16'h9605);
    chk("R12 reset pins", {adapter_reset, cpu_halt, boot_sel, diag_loop, sys_int_en,
        parity_en, sel_out, pdma_en}, 9'b0_1_1_0_1_0_10_0);
  endtask

  task automatic t_cfg();
    cfg_pin = 3'b001; #1;
    chk("R2 low third pin reserved", {rd_data[2:0], speed_code}, {3'b001, 2'b00});
    cfg_pin = 3'b100; #1;
    chk("R2 16M decode", {rd_data[2:0], speed_code}, {3'b100, 2'b10});
    cfg_pin = 3'b101; #1;
    chk("R2 4M decode", {rd_data[2:0], speed_code}, {3'b101, 2'b01});
    cfg_pin = 3'b100; #1;
  endtask

  task automatic t_disabled();
    do_reset(1'b0, 1'b0);
    chk("R1 reset word boot=0 par=0", rd_data, 16'h9004);
    hw_hold_ack = 1'b1; #1;
    chk("R10 pin passes while disabled", hold_ack_eff, 1'b1);
    hw_hold_ack = 1'b0; #1;
    chk("R10 pin low passes while disabled", hold_ack_eff, 1'b0);
    wr(2'b01, 16'h0010);
    chk("R8 ack refused while disabled", rd_data, 16'h9004);
    pulse_req();
    chk("R9 request ignored while disabled", {rd_data[6], pdma_state}, 3'b000);
  endtask

  task automatic t_protect();
    wr(2'b11, 16'h6E00);
    chk("R5 protected bits ignored", rd_data, 16'h8804);
    chk("R12 diag_loop follows bit 11", diag_loop, 1'b1);
  endtask

  task automatic t_rw();
    wr(2'b10, 16'h1100);
    chk("R4 high-lane write", rd_data, 16'h9104);
    chk("R12 adapter_reset pin", {adapter_reset, sys_int_en}, 2'b11);
    wr(2'b01, 16'h00FF);
    chk("R4 low lane leaves high byte", rd_data[15:8], 8'h91);
    chk("R7 set-only bit set", rd_data[7], 1'b1);
    chk("R8 ack gated by prior enable", rd_data[4], 1'b0);
    chk("R3 reserved bits read zero", {rd_data[5], rd_data[3]}, 2'b00);
    chk("R2 pin bits not writable", rd_data[2:0], 3'b100);
  endtask

  task automatic t_open();
    wr(2'b11, 16'h7600);
    chk("R6 write lands while clearing bit 8", rd_data, 16'h7684);
    chk("R12 pins after protected write", {adapter_reset, cpu_halt, boot_sel,
        sys_int_en, parity_en, sel_out}, 8'b0_1_1_1_1_01);
    wr(2'b10, 16'h8000);
    chk("R5 closed again after bit 8 cleared", rd_data, 16'h6684);
  endtask

  task automatic t_setonly();
    wr(2'b01, 16'h0000);
    chk("R7 zero write keeps enable", {rd_data[7], pdma_en}, 2'b11);
  endtask

  task automatic t_pdma();
    hw_hold_ack = 1'b1; #1;
    chk("R10 pin ignored when enabled", hold_ack_eff, 1'b0);
    chk("R11 idle", pdma_state, 2'b00);
    pulse_req();
    chk("R9 request latched", rd_data[6], 1'b1);
    chk("R11 pending", pdma_state, 2'b01);
    wr(2'b01, 16'h0080);
    chk("R9 request not cleared by write", rd_data[6], 1'b1);
    hw_hold_ack = 1'b0;
    wr(2'b01, 16'h0010);
    chk("R9 ack clears request", {rd_data[6], rd_data[4]}, 2'b01);
    chk("R11 busy", pdma_state, 2'b10);
    chk("R10 software ack drives output", hold_ack_eff, 1'b1);
    pulse_req();
    chk("R9 no request while busy", rd_data[6], 1'b0);
    wr(2'b01, 16'h0000);
    chk("R11 back to idle", {pdma_state, rd_data[4]}, 3'b000);
  endtask

  task automatic t_reset_b();
    do_reset(1'b0, 1'b1);
    chk("R1 reset word boot=0 par=1", rd_data, 16'hB004);
    chk("R7 reset clears enable", pdma_en, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset_a();
    t_cfg();
    t_disabled();
    t_protect();
    t_rw();
    t_open();
    t_setonly();
    t_pdma();
    t_reset_b();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule